// File: doc/BRIEF.md
# Shared/Exclusive Page Lock Arbiter

This block keeps track of which protected pages are currently owned by page-load instructions that are in flight. An acquiring instruction presents a destination page, which it needs alone, and up to two more pages, a version slot and a parent context, which it may share with other holders. In a single cycle the arbiter either takes every requested lock or takes none of them and reports a conflict.

A conflict is reported in one of three ways. The choice depends on the instruction class and on the requester's virtualization state. A legacy-class instruction gets a general-protection fault. A conflict-reporting instruction gets a returned error code, with the zero flag set and the carry flag clear. A requester running virtualized with the extension enabled gets a virtualization exit, but only when the conflict is on the destination page. The exit carries a qualification code and the destination's linear address. Releases name the same page addresses that were acquired and free the locks. Any release of a lock that is not held latches an error flag.

The lock table holds `ENTRIES` entries. Each entry has a page tag, an exclusive bit and a shared-holder count that is `CNT_W` bits wide.

Top module: `page_lock_arbiter`

## Requirements
- R1: After reset no result is valid, `rel_err` is 0, and the table is empty, so a first acquire of any page is granted.
- R2: If an acquire has no conflict, one cycle later it returns `res_grant`=1, `res_zf`=0, `res_code`=0 and `res_which`=0. The destination page is then held exclusive. The version-slot and context pages are held shared, so a later acquire that uses them as shared operands is also granted.
- R3: The destination conflicts with any held lock on its page, whether that lock is shared or exclusive. A shared operand conflicts with a page that is held exclusive. A shared operand does not conflict with a page that is held shared.
- R4: Acquisition is all-or-nothing: after a conflicting acquire, no part of the request remains held.
- R5: Conflicts are checked in the order destination, then version slot, then context. `res_which` reports the first operand that conflicts, encoded 1 = destination, 2 = version slot, 3 = context.
- R6: For a legacy-class request (`acq_report`=0), a conflict that does not cause an exit gives `res_fault`=1.
- R7: For a conflict-reporting request (`acq_report`=1), a conflict that does not cause an exit gives `res_zf`=1 with `res_code`=CONFLICT_CODE, and no fault.
- R8: If `acq_virt`=1 and the destination conflicts, the result is `res_exit`=1 and `res_exit_lin` is set to `acq_lin`. For a legacy request, `res_exit_qual` is 0 and `res_exit_err` is 0. For a conflict-reporting request, `res_exit_qual` is 1 and `res_exit_err` is CONFLICT_CODE.
- R9: If `acq_virt`=1 and the conflict is on the version slot or the context, no exit is taken and the result follows R6 or R7.
- R10: An operand also conflicts if the table has no free entry for it, or if adding it would push a shared count beyond 2^CNT_W-1.
- R11: A release clears the exclusive bit or lowers the shared count. An entry is freed only when its count reaches zero, and a page freed this way can then be acquired again.
- R12: A release that names a lock that is not held sets `rel_err`, and `rel_err` stays set until reset.
- R13: If a shared operand names the destination's own page, that operand conflicts. An operand whose use bit is 0 is neither checked nor taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Acquire request |
| acq_report | input | 1 | 1 = conflict-reporting class, 0 = legacy class |
| acq_virt | input | 1 | Requester is virtualized with the extension enabled |
| acq_dst | input | ADDR_W | Destination page, acquired exclusive |
| acq_va_use | input | 1 | Version-slot operand is present |
| acq_va | input | ADDR_W | Version-slot page, acquired shared |
| acq_ctx_use | input | 1 | Context operand is present |
| acq_ctx | input | ADDR_W | Parent-context page, acquired shared |
| acq_lin | input | LIN_W | Linear address of the destination, reported on an exit |
| rel_valid | input | 1 | Release request |
| rel_dst | input | ADDR_W | Exclusive page to release |
| rel_va_use | input | 1 | Release a version-slot share |
| rel_va | input | ADDR_W | Version-slot page to release |
| rel_ctx_use | input | 1 | Release a context share |
| rel_ctx | input | ADDR_W | Context page to release |
| res_valid | output | 1 | Acquire result is valid |
| res_grant | output | 1 | All requested locks were taken |
| res_fault | output | 1 | General-protection fault |
| res_zf | output | 1 | Zero flag of a returned error |
| res_code | output | CODE_W | Returned error code |
| res_exit | output | 1 | Virtualization exit |
| res_exit_qual | output | 1 | Exit qualification: 0 = conflict exception, 1 = conflict error |
| res_exit_err | output | CODE_W | Error field of the exit |
| res_exit_lin | output | LIN_W | Linear address reported with the exit |
| res_which | output | 2 | Operand that conflicted first |
| rel_err | output | 1 | Sticky flag for a release of a lock that is not held |

## Verification
Every acquire result is registered. It appears on the rising edge that follows the cycle in which `acq_valid` is high. The table update for a grant or a release lands on that same edge, and `rel_err` rises on that edge after a bad release.

The driver raises each request just after a falling edge and drops it at the next falling edge. At the moment it drops the request, the monitor compares the result that was captured one edge earlier with the head of the expected queue. Effects on the table are observed only through later acquires and through `rel_err`, so every check samples at least one full edge after its stimulus.

// File: rtl/page_lock_arbiter.sv
module page_lock_arbiter #(
  parameter int ADDR_W = 36,
  parameter int LIN_W = 48,
  parameter int ENTRIES = 8,
  parameter int CNT_W = 2,
  parameter int CODE_W = 16,
  parameter logic [CODE_W-1:0] CONFLICT_CODE = 'd23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_valid,
  input  logic              acq_report,
  input  logic              acq_virt,
  input  logic [ADDR_W-1:0] acq_dst,
  input  logic              acq_va_use,
  input  logic [ADDR_W-1:0] acq_va,
  input  logic              acq_ctx_use,
  input  logic [ADDR_W-1:0] acq_ctx,
  input  logic [LIN_W-1:0]  acq_lin,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_dst,
  input  logic              rel_va_use,
  input  logic [ADDR_W-1:0] rel_va,
  input  logic              rel_ctx_use,
  input  logic [ADDR_W-1:0] rel_ctx,
  output logic              res_valid,
  output logic              res_grant,
  output logic              res_fault,
  output logic              res_zf,
  output logic [CODE_W-1:0] res_code,
  output logic              res_exit,
  output logic              res_exit_qual,
  output logic [CODE_W-1:0] res_exit_err,
  output logic [LIN_W-1:0]  res_exit_lin,
  output logic [1:0]        res_which,
  output logic              rel_err
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int FC_W = $clog2(ENTRIES + 1);
  localparam logic [CNT_W:0] CMAX = {1'b0, {CNT_W{1'b1}}};

  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [ADDR_W-1:0] tag_d [ENTRIES];
  logic [CNT_W-1:0]  cnt_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_d [ENTRIES];
  logic [ENTRIES-1:0] x_q, x_d, ent_v, mixed;

  always_comb
    for (int i = 0; i < ENTRIES; i++) begin
      ent_v[i] = x_q[i] | (|cnt_q[i]);
      mixed[i] = x_q[i] & (|cnt_q[i]);
    end

  // table lookup for acquire and release operands
  logic dst_hit, va_hit, va_x, ctx_hit, ctx_x;
  logic [CNT_W-1:0] va_cnt, ctx_cnt, rv_cnt;
  logic [IDX_W-1:0] va_idx, ctx_idx, s0, s1, s2;
  logic [FC_W-1:0] nfree;
  logic rd_hit, rv_hit, rc_hit;
  logic [IDX_W-1:0] rd_idx, rv_idx, rc_idx;

  always_comb begin
    dst_hit = 1'b0; va_hit = 1'b0; va_x = 1'b0; va_cnt = '0; va_idx = '0;
    ctx_hit = 1'b0; ctx_x = 1'b0; ctx_cnt = '0; ctx_idx = '0;
    rd_hit = 1'b0; rd_idx = '0; rv_hit = 1'b0; rv_idx = '0; rv_cnt = '0;
    rc_hit = 1'b0; rc_idx = '0;
    nfree = '0; s0 = '0; s1 = '0; s2 = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_v[i]) begin
        if (tag_q[i] == acq_dst) dst_hit = 1'b1;
        if (tag_q[i] == acq_va) begin
          va_hit = 1'b1; va_x = x_q[i]; va_cnt = cnt_q[i]; va_idx = IDX_W'(i);
        end
        if (tag_q[i] == acq_ctx) begin
          ctx_hit = 1'b1; ctx_x = x_q[i]; ctx_cnt = cnt_q[i]; ctx_idx = IDX_W'(i);
        end
        if (x_q[i] && tag_q[i] == rel_dst) begin rd_hit = 1'b1; rd_idx = IDX_W'(i); end
        if (!x_q[i] && tag_q[i] == rel_va) begin
          rv_hit = 1'b1; rv_idx = IDX_W'(i); rv_cnt = cnt_q[i];
        end
        if (!x_q[i] && tag_q[i] == rel_ctx) begin rc_hit = 1'b1; rc_idx = IDX_W'(i); end
      end else begin
        if (nfree == FC_W'(0)) s0 = IDX_W'(i);
        if (nfree == FC_W'(1)) s1 = IDX_W'(i);
        if (nfree == FC_W'(2)) s2 = IDX_W'(i);
        nfree = nfree + 1'b1;
      end
    end
  end

  // conflict evaluation, destination first
  logic same, va_new, ctx_new, dst_c, va_c, ctx_c, take;
  logic [CNT_W-1:0] va_inc;
  logic [IDX_W-1:0] ctx_slot;

  assign same    = acq_va_use & acq_ctx_use & (acq_va == acq_ctx);
  assign va_new  = acq_va_use & ~va_hit;
  assign ctx_new = acq_ctx_use & ~ctx_hit & ~same;
  assign va_inc  = same ? CNT_W'(2) : CNT_W'(1);
  assign ctx_slot = va_new ? s2 : s1;

  assign dst_c = dst_hit | (nfree == '0);
  assign va_c  = acq_va_use & ((acq_va == acq_dst) | va_x |
                 (va_hit & ({1'b0, va_cnt} == CMAX)) |
                 (~va_hit & (nfree < FC_W'(2))));
  assign ctx_c = acq_ctx_use & ((acq_ctx == acq_dst) | ctx_x |
                 (ctx_hit & (({1'b0, ctx_cnt} + (same ? 2'd2 : 2'd1)) > CMAX)) |
                 (ctx_new & (nfree < (va_new ? FC_W'(3) : FC_W'(2)))));
  assign take  = acq_valid & ~(dst_c | va_c | ctx_c);

  // release validation
  logic rsame, rv_bad, rc_bad, rd_bad;
  logic [CNT_W-1:0] rneed;
  assign rsame  = rel_va_use & rel_ctx_use & (rel_va == rel_ctx);
  assign rneed  = rsame ? CNT_W'(2) : CNT_W'(1);
  assign rd_bad = ~rd_hit;
  assign rv_bad = rel_va_use & ~(rv_hit & (rv_cnt >= rneed));
  assign rc_bad = rel_ctx_use & ~rsame & ~rc_hit;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      tag_d[i] = tag_q[i]; cnt_d[i] = cnt_q[i];
    end
    x_d = x_q;
    if (take) begin
      tag_d[s0] = acq_dst;
      x_d[s0] = 1'b1;
      if (va_new) begin
        tag_d[s1] = acq_va;
        cnt_d[s1] = va_inc;
      end else if (acq_va_use) cnt_d[va_idx] = cnt_d[va_idx] + va_inc;
      if (ctx_new) begin
        tag_d[ctx_slot] = acq_ctx;
        cnt_d[ctx_slot] = CNT_W'(1);
      end else if (acq_ctx_use && !same) cnt_d[ctx_idx] = cnt_d[ctx_idx] + CNT_W'(1);
    end
    if (rel_valid) begin
      if (rd_hit) x_d[rd_idx] = 1'b0;
      if (rel_va_use && !rv_bad) cnt_d[rv_idx] = cnt_d[rv_idx] - rneed;
      if (rel_ctx_use && !rsame && !rc_bad) cnt_d[rc_idx] = cnt_d[rc_idx] - CNT_W'(1);
    end
  end

  logic exit_n;
  assign exit_n = acq_virt & dst_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0; cnt_q[i] <= '0;
      end
      res_valid <= 1'b0; res_grant <= 1'b0; res_fault <= 1'b0; res_zf <= 1'b0;
      res_code <= '0; res_exit <= 1'b0; res_exit_qual <= 1'b0; res_exit_err <= '0;
      res_exit_lin <= '0; res_which <= '0; rel_err <= 1'b0;
    end else begin
      x_q <= x_d;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= tag_d[i]; cnt_q[i] <= cnt_d[i];
      end
      res_valid     <= acq_valid;
      res_grant     <= take;
      res_exit      <= acq_valid & ~take & exit_n;
      res_fault     <= acq_valid & ~take & ~exit_n & ~acq_report;
      res_zf        <= acq_valid & ~take & ~exit_n & acq_report;
      res_code      <= (acq_valid & ~take & ~exit_n & acq_report) ? CONFLICT_CODE : '0;
      res_exit_qual <= acq_valid & ~take & exit_n & acq_report;
      res_exit_err  <= (acq_valid & ~take & exit_n & acq_report) ? CONFLICT_CODE : '0;
      res_exit_lin  <= (acq_valid & ~take & exit_n) ? acq_lin : '0;
      res_which     <= (!acq_valid || take) ? 2'd0 : dst_c ? 2'd1 : va_c ? 2'd2 : 2'd3;
      rel_err       <= rel_err | (rel_valid & (rd_bad | rv_bad | rc_bad));
    end
  end

  a_r3_excl_alone: assert property (@(posedge clk) disable iff (!rst_n) mixed == '0);
  a_r4_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && !rel_valid) |=> (res_grant || $countones(ent_v) == $past($countones(ent_v))));
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot({res_grant, res_fault, res_zf, res_exit}));
  a_r8_exit_on_dst: assert property (@(posedge clk) disable iff (!rst_n)
    res_exit |-> (res_which == 2'd1));
  a_r2_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
    res_grant |-> ($countones(ent_v) != 0));
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n) rel_err |=> rel_err);
endmodule

// File: tb/page_lock_arbiter_tb.sv
`timescale 1ns/1ps
module page_lock_arbiter_tb;
  localparam logic [15:0] CODE = 16'd23;
  localparam int KG = 0, KF = 1, KE = 2, KX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic acq_valid = 0, acq_report = 0, acq_virt = 0, acq_va_use = 0, acq_ctx_use = 0;
  logic [35:0] acq_dst = 0, acq_va = 0, acq_ctx = 0;
  logic [47:0] acq_lin = 0;
  logic rel_valid = 0, rel_va_use = 0, rel_ctx_use = 0;
  logic [35:0] rel_dst = 0, rel_va = 0, rel_ctx = 0;
  logic res_valid, res_grant, res_fault, res_zf, res_exit, res_exit_qual, rel_err;
  logic [15:0] res_code, res_exit_err;
  logic [47:0] res_exit_lin;
  logic [1:0] res_which;

  page_lock_arbiter u_dut (.*);

  typedef struct packed {
    logic g, f, z; logic [15:0] code; logic x, q; logic [15:0] xe; logic [47:0] lin; logic [1:0] w;
  } exp_t;
  exp_t q[$];
  string tq[$];
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", tag, msg); end
  endtask

  always @(negedge clk) if (rst_n && res_valid) begin
    exp_t a, e;
    string t;
    a = '{res_grant, res_fault, res_zf, res_code, res_exit, res_exit_qual, res_exit_err, res_exit_lin, res_which};
    if (q.size() == 0) chk(0, "R2", "result with nothing expected");
    else begin
      e = q.pop_front(); t = tq.pop_front();
      chk(a == e, t, $sformatf("actual %h expected %h", a, e));
    end
  end

  task automatic acq(input bit rep, input bit virt, input logic [35:0] d, input bit vu,
                     input logic [35:0] v, input bit cu, input logic [35:0] c,
                     input int kind, input logic [1:0] wh, input string tag);
    exp_t e;
    e = '0;
    case (kind)
      KG: e.g = 1;
      KF: begin e.f = 1; e.w = wh; end
      KE: begin e.z = 1; e.code = CODE; e.w = wh; end
      default: begin e.x = 1; e.q = rep; e.xe = rep ? CODE : 16'd0; e.lin = {12'h7ab, d}; e.w = wh; end
    endcase
    @(negedge clk);
    q.push_back(e); tq.push_back(tag);
    acq_valid = 1; acq_report = rep; acq_virt = virt; acq_dst = d; acq_va_use = vu;
    acq_va = v; acq_ctx_use = cu; acq_ctx = c; acq_lin = {12'h7ab, d};
    @(negedge clk);
    acq_valid = 0;
  endtask

  task automatic rel(input logic [35:0] d, input bit vu, input logic [35:0] v,
                     input bit cu, input logic [35:0] c);
    @(negedge clk);
    rel_valid = 1; rel_dst = d; rel_va_use = vu; rel_va = v; rel_ctx_use = cu; rel_ctx = c;
    @(negedge clk);
    rel_valid = 0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired");
    finish_run();
  end

  localparam logic [35:0] A1 = 36'h101, A2 = 36'h102, A3 = 36'h103, A4 = 36'h104,
    A5 = 36'h105, A6 = 36'h106, A7 = 36'h107, A8 = 36'h108, A9 = 36'h109,
    V = 36'h200, S = 36'h300;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0 && rel_err == 0, "R1", $sformatf("reset valid=%b err=%b exp 0 0", res_valid, rel_err));
    acq(0, 0, A1, 1, V, 1, S, KG, 0, "R1");
    acq(0, 0, A2, 1, V, 1, S, KG, 0, "R2");
    acq(0, 0, A1, 0, 0, 0, 0, KF, 1, "R3");
    acq(1, 0, V, 0, 0, 0, 0, KE, 1, "R7");
    acq(0, 0, A3, 1, A1, 0, 0, KF, 2, "R6");
    acq(1, 1, A2, 1, A1, 0, 0, KX, 1, "R8");
    acq(0, 1, A1, 0, 0, 0, 0, KX, 1, "R8");
    acq(1, 1, A4, 1, A1, 0, 0, KE, 2, "R9");
    acq(0, 1, A4, 0, 0, 1, A2, KF, 3, "R9");
    acq(1, 0, A4, 1, A1, 1, A2, KE, 2, "R5");
    acq(0, 0, A3, 0, 0, 0, 0, KG, 0, "R4");
    acq(0, 0, A5, 1, V, 0, 0, KG, 0, "R2");
    acq(0, 0, A6, 1, V, 0, 0, KF, 2, "R10");
    acq(0, 0, A6, 1, A6, 0, 0, KF, 2, "R13");
    acq(0, 0, A6, 0, A1, 0, A2, KG, 0, "R13");
    acq(0, 0, A7, 0, 0, 0, 0, KG, 0, "R10");
    acq(0, 0, A8, 0, 0, 0, 0, KF, 1, "R10");
    acq(1, 0, A8, 0, 0, 0, 0, KE, 1, "R10");
    rel(A7, 0, 0, 0, 0);
    acq(0, 0, A8, 0, 0, 0, 0, KG, 0, "R11");
    rel(A5, 1, V, 0, 0);
    rel(A2, 1, V, 1, S);
    acq(0, 0, V, 0, 0, 0, 0, KF, 1, "R11");
    rel(A1, 1, V, 1, S);
    acq(0, 0, V, 0, 0, 0, 0, KG, 0, "R11");
    chk(rel_err == 0, "R12", $sformatf("rel_err=%b exp 0 after valid releases", rel_err));
    rel(A9, 0, 0, 0, 0);
    chk(rel_err == 1, "R12", $sformatf("rel_err=%b exp 1 after unheld release", rel_err));
    rel(A3, 0, 0, 0, 0);
    chk(rel_err == 1, "R12", $sformatf("rel_err=%b exp 1 sticky", rel_err));
    acq(0, 0, A3, 0, 0, 0, 0, KG, 0, "R11");
    @(negedge clk);
    chk(q.size() == 0, "R2", $sformatf("pending %0d exp 0", q.size()));
    finish_run();
  end
endmodule